// File: doc/BRIEF.md
# Level Width Measurement Timer

This block is one timer channel that measures how long an input pin stays at a chosen level. It can time how long the pin stays high or how long it stays low. Software arms it with a one-cycle start strobe. The channel then waits for the edge that begins the chosen level, clears its counter and counts prescaled ticks. On the edge that ends the level, it copies the count into a capture register and raises a one-cycle interrupt. The counter then freezes until the next beginning edge, so the channel measures repeated pulses without being re-armed.

The pin first passes through a two-flop synchronizer. An optional glitch filter follows, and it accepts a new level only after two consecutive samples agree. The prescaler divides the system clock by a power of two, and its phase restarts on every beginning edge. Each capture rewrites the overflow flag: it is set if the counter wrapped during the measured interval and cleared if it did not. A stop strobe disables the channel and leaves the counter and the overflow flag as they are.

Top module: `lvl_width_timer`

## Requirements
- R1: After reset, `enabled_o`, `count_o`, `capture_o`, `ovf_o` and `irq_o` are all zero.
- R2: A `start_i` strobe sets `enabled_o` to 1. The channel then waits for a beginning edge, and an ending edge seen before any beginning edge produces no capture and no interrupt.
- R3: A beginning edge clears the counter to 0 and restarts the prescaler phase. The counter then adds one every 2^`presc_sel_i` clocks. For a level held N clocks at the pin, the captured value is floor((N-1)/2^`presc_sel_i`) modulo 2^CNT_W.
- R4: With `meas_low_i` = 0 the beginning edge is rising and the ending edge is falling. With `meas_low_i` = 1 the pair is reversed.
- R5: On an ending edge while counting, the count is copied to `capture_o` and `irq_o` is high for exactly one clock. There is exactly one pulse per measured level.
- R6: After a capture, `count_o` holds the captured value until the next beginning edge.
- R7: Each capture sets `ovf_o` to 1 if the counter wrapped from all-ones to zero since the beginning edge, and to 0 otherwise. A capture in the same tick that would wrap takes priority, so no wrap is recorded.
- R8: A `stop_i` strobe clears `enabled_o`. `count_o`, `capture_o` and `ovf_o` then hold, and later pin edges have no effect. Stop wins over a simultaneous start.
- R9: With `nf_en_i` = 1, a pin level lasting one clock is rejected and one lasting two clocks is accepted. With `nf_en_i` = 0, a one-clock level is accepted. Both edges of a level see the same latency.
- R10: `count_o` shows the live counter during a measurement and advances by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe (self-clearing trigger) |
| stop_i | input | 1 | One-cycle stop strobe (self-clearing trigger) |
| meas_low_i | input | 1 | 0: measure high level, 1: measure low level |
| nf_en_i | input | 1 | Glitch filter enable |
| presc_sel_i | input | PS_W | Tick period is 2^presc_sel_i clocks |
| pin_i | input | 1 | Asynchronous input being measured |
| enabled_o | output | 1 | Channel enable status |
| count_o | output | CNT_W | Live counter value |
| capture_o | output | CNT_W | Last captured width |
| ovf_o | output | 1 | Overflow status of the last capture |
| irq_o | output | 1 | One-cycle capture interrupt |

## Verification
The bench arms the channel while the pin already sits at the measured level. A design that captures without a beginning edge would then raise a spurious interrupt. It times a level of exactly 2^CNT_W clocks, where the final wrap and the capture share a tick. A design that lets the increment win would report overflow and lose the count. A stop strobe is issued mid-measurement after an overflowed capture, which exposes a design that clears the flag or keeps counting. One- and two-clock pulses are sent with the filter on and off, which catches a filter that is too eager or too strict.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    typedef enum logic {
        MEAS_HIGH = 1'b0,
        MEAS_LOW  = 1'b1
    } meas_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

endpackage

// File: rtl/lwt_infilt.sv
module lwt_infilt
    import lwt_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  pin_i,
    input  logic  nf_en_i,
    output edge_t edge_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic smp;
        logic lvl;
        logic prev;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.s1   = pin_i;
        d.s2   = q.s1;
        d.smp  = q.s2;
        // with the filter on, a level is taken only once two samples agree
        if (!nf_en_i || (q.s2 == q.smp)) begin
            d.lvl = q.s2;
        end
        d.prev = q.lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign edge_o.rise = q.lvl & ~q.prev;
    assign edge_o.fall = ~q.lvl & q.prev;

    // R9: with filtering on, the level only moves after two agreeing samples
    p_filter_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(nf_en_i) && (q.lvl != $past(q.lvl))) |-> $past(q.s2 == q.smp));

endmodule

// File: rtl/lwt_presc.sv
module lwt_presc #(
    parameter int PS_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clr_i,
    input  logic [PS_W-1:0] sel_i,
    output logic            tick_o
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q, div_d, mask;

    always_comb begin
        mask  = (DIV_W'(1) << sel_i) - DIV_W'(1);
        div_d = clr_i ? '0 : div_q + DIV_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = ((div_q & mask) == mask);

    // R3: right after a phase restart a tick is present only for divide-by-one
    p_phase_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(clr_i) && $stable(sel_i)) |-> (tick_o == (sel_i == '0)));

endmodule

// File: rtl/lwt_core.sv
module lwt_core
    import lwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  meas_e            meas_i,
    input  edge_t            edge_i,
    input  logic             tick_i,
    output logic             start_ev_o,
    output logic             en_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             ovf_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             en;
        logic             run;
        logic             wrap;
        logic             ovf;
        logic             irq;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
    } core_t;

    core_t q, d;
    logic  start_ev, cap_ev;

    always_comb begin
        start_ev = (meas_i == MEAS_LOW) ? edge_i.fall : edge_i.rise;
        cap_ev   = (meas_i == MEAS_LOW) ? edge_i.rise : edge_i.fall;

        d     = q;
        d.irq = 1'b0;
        if (stop_i) begin
            d.en  = 1'b0;
            d.run = 1'b0;
        end else if (start_i) begin
            d.en  = 1'b1;
            d.run = 1'b0;
        end else if (q.en) begin
            if (start_ev) begin
                d.cnt  = '0;
                d.run  = 1'b1;
                d.wrap = 1'b0;
            end else if (q.run && cap_ev) begin
                d.cap = q.cnt;
                d.ovf = q.wrap;
                d.irq = 1'b1;
                d.run = 1'b0;
            end else if (q.run && tick_i) begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_MAX) begin
                    d.wrap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_ev_o = start_ev;
    assign en_o       = q.en;
    assign cnt_o      = q.cnt;
    assign cap_o      = q.cap;
    assign ovf_o      = q.ovf;
    assign irq_o      = q.irq;

    // R2: a start strobe enables the channel and leaves it waiting
    p_start_arms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !stop_i) |=> (q.en && !q.run));

    // R3: a beginning edge while enabled restarts the count from zero
    p_start_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.en && start_ev && !start_i && !stop_i) |=> (q.cnt == '0 && q.run));

    // R5: interrupt lasts exactly one clock
    p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.irq |=> !q.irq);

    // R5: the captured value equals the count at capture
    p_cap_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.irq |-> (q.cap == q.cnt));

    // R6: counter frozen while not running and no restart
    p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!q.run && !start_ev) |=> $stable(q.cnt));

    // R7: overflow flag reflects the wrap state seen at capture
    p_ovf_rewrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.irq |-> (q.ovf == $past(q.wrap)));

    // R8: stop disables and holds results
    p_stop_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!q.en && $stable(q.ovf) && $stable(q.cnt) && $stable(q.cap)));

endmodule

// File: rtl/lvl_width_timer.sv
module lvl_width_timer
    import lwt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             meas_low_i,
    input  logic             nf_en_i,
    input  logic [PS_W-1:0]  presc_sel_i,
    input  logic             pin_i,
    output logic             enabled_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             ovf_o,
    output logic             irq_o
);

    edge_t edge_w;
    logic  tick_w;
    logic  start_ev_w;
    meas_e meas_w;

    assign meas_w = meas_e'(meas_low_i);

    lwt_infilt u_filt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .nf_en_i (nf_en_i),
        .edge_o  (edge_w)
    );

    lwt_presc #(
        .PS_W (PS_W)
    ) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start_ev_w),
        .sel_i  (presc_sel_i),
        .tick_o (tick_w)
    );

    lwt_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .meas_i     (meas_w),
        .edge_i     (edge_w),
        .tick_i     (tick_w),
        .start_ev_o (start_ev_w),
        .en_o       (enabled_o),
        .cnt_o      (count_o),
        .cap_o      (capture_o),
        .ovf_o      (ovf_o),
        .irq_o      (irq_o)
    );

    // R1: outputs are quiet in the first clock after reset
    p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!irq_o && !ovf_o));

endmodule

// File: tb/lvl_width_timer_tb_top.sv
module lvl_width_timer_tb_top;

    localparam int CW  = 8;
    localparam int PSW = 4;

    // fields: meas_low, nf_en, presc_sel, width N, expected capture, expected ovf
    localparam int TV [7][6] = '{
        '{0, 0, 0,  10,   9, 0},
        '{1, 0, 0,  20,  19, 0},
        '{0, 1, 0,   7,   6, 0},
        '{0, 0, 2,  37,   9, 0},
        '{1, 1, 1,  50,  24, 0},
        '{1, 0, 0, 256, 255, 0},
        '{0, 0, 0, 300,  43, 1}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start_i, stop_i, meas_low, nf_en, pin;
    logic [PSW-1:0] presc_sel;
    logic           enabled_o, ovf_o, irq_o;
    logic [CW-1:0]  count_o, capture_o;

    int  n_chk = 0;
    int  n_fail = 0;
    int  irq_total = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    lvl_width_timer #(.CNT_W(CW), .PS_W(PSW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .meas_low_i  (meas_low),
        .nf_en_i     (nf_en),
        .presc_sel_i (presc_sel),
        .pin_i       (pin),
        .enabled_o   (enabled_o),
        .count_o     (count_o),
        .capture_o   (capture_o),
        .ovf_o       (ovf_o),
        .irq_o       (irq_o)
    );

    always @(negedge clk) if (irq_o === 1'b1) irq_total++;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trig_start();
        start_i = 1'b1;
        cyc(1);
        start_i = 1'b0;
    endtask

    task automatic measure(input int low, input int nf, input int sel, input int n,
                           output int cap, output int ovf, output int nirq, output int cnt);
        int base;
        meas_low  = low[0];
        nf_en     = nf[0];
        presc_sel = sel[PSW-1:0];
        pin       = low[0];
        cyc(6);
        trig_start();
        cyc(3);
        base = irq_total;
        pin  = ~low[0];
        cyc(n);
        pin  = low[0];
        cyc(10);
        cap  = int'(capture_o);
        ovf  = int'(ovf_o);
        nirq = irq_total - base;
        cnt  = int'(count_o);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int cap, ovf, nirq, cnt, base, c1, c2, c3;
        rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
        meas_low = 1'b0; nf_en = 1'b0; presc_sel = '0; pin = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        check("R1 enabled", int'(enabled_o), 0);
        check("R1 count", int'(count_o), 0);
        check("R1 capture", int'(capture_o), 0);
        check("R1 ovf", int'(ovf_o), 0);
        check("R1 irq", irq_total, 0);

        // R2: armed while pin already high; the falling edge must not capture
        pin = 1'b1;
        cyc(6);
        trig_start();
        check("R2 enabled after start", int'(enabled_o), 1);
        base = irq_total;
        pin = 1'b0;
        cyc(10);
        check("R2 no capture before start edge", irq_total - base, 0);
        check("R2 counter untouched", int'(count_o), 0);

        // R3 R4 R5 R6 R7: table of measurements
        for (int i = 0; i < 7; i++) begin
            measure(TV[i][0], TV[i][1], TV[i][2], TV[i][3], cap, ovf, nirq, cnt);
            check($sformatf("R3 R4 capture row %0d", i), cap, TV[i][4]);
            check($sformatf("R7 ovf row %0d", i), ovf, TV[i][5]);
            check($sformatf("R5 single irq row %0d", i), nirq, 1);
            check($sformatf("R6 frozen count row %0d", i), cnt, TV[i][4]);
        end

        // R10: live count advances during a measurement
        meas_low = 1'b0; nf_en = 1'b0; presc_sel = '0; pin = 1'b0;
        cyc(6);
        trig_start();
        cyc(3);
        base = irq_total;
        pin = 1'b1;
        cyc(10);
        c1 = int'(count_o);
        cyc(5);
        c2 = int'(count_o);
        check("R10 live count step", c2 - c1, 5);

        // R8: stop mid-measurement holds everything
        stop_i = 1'b1;
        cyc(1);
        stop_i = 1'b0;
        check("R8 enabled cleared", int'(enabled_o), 0);
        c3 = int'(count_o);
        pin = 1'b0;
        cyc(10);
        check("R8 count held", int'(count_o), c3);
        check("R8 no irq after stop", irq_total - base, 0);
        check("R8 ovf held", int'(ovf_o), 1);
        check("R8 capture held", int'(capture_o), 43);

        // R7: next capture without wrap clears the flag
        measure(0, 0, 0, 5, cap, ovf, nirq, cnt);
        check("R7 ovf cleared", ovf, 0);
        check("R3 short width", cap, 4);

        // R9: one-clock glitch rejected with filter on
        meas_low = 1'b0; nf_en = 1'b1; presc_sel = '0; pin = 1'b0;
        cyc(6);
        trig_start();
        cyc(3);
        base = irq_total;
        pin = 1'b1;
        cyc(1);
        pin = 1'b0;
        cyc(10);
        check("R9 glitch rejected irq", irq_total - base, 0);
        check("R9 glitch rejected count", int'(count_o), 4);

        // R9: two-clock level accepted with filter on
        measure(0, 1, 0, 2, cap, ovf, nirq, cnt);
        check("R9 two-clock accepted irq", nirq, 1);
        check("R9 two-clock capture", cap, 1);

        // R9: one-clock level accepted with filter off
        measure(0, 0, 0, 1, cap, ovf, nirq, cnt);
        check("R9 unfiltered one-clock irq", nirq, 1);
        check("R9 unfiltered one-clock capture", cap, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule